// File: doc/BRIEF.md
# Lane Drive Level Clamp

During link training the sink asks for new drive levels on each lane: a voltage swing and a pre-emphasis level, and optionally a post-cursor2 level. This block takes those packed requests, limits each lane to a legal setting, and produces three things. The first is the per-lane configuration bytes that go back to the sink. The second is the packed post-cursor2 configuration bytes. The third is the plain 2-bit swing, pre-emphasis and post-cursor2 levels for the transmitter PHY.

The swing ceiling is not fixed. It shrinks as the requested pre-emphasis grows, so that swing plus pre-emphasis never exceeds level 3. When a value is limited, the matching "maximum reached" flag is set inside the configuration byte so the sink stops asking for more.

A one-cycle `start_i` pulse samples the requests and the active lane count. One clock later the results appear on registered outputs together with a one-cycle `done_o` pulse. The outputs then hold until the next start.

Top module: `lt_drive_clamp`

## Requirements
- R1: When `start_i` is sampled high on a rising edge, `done_o` is high for exactly the following cycle and all outputs carry the new result in that cycle. Without `start_i`, `done_o` is low and every output holds its value.
- R2: The request for lane i is the nibble `adj_req_i[4*i+3:4*i]`, so byte i>>1 holds lanes 2k (low nibble) and 2k+1 (high nibble). Within the nibble, bits [1:0] are the requested swing and bits [3:2] the requested pre-emphasis.
- R3: A requested pre-emphasis of 3 yields pre-emphasis 3 with its max flag and swing 0 with no flag. The lane configuration byte is then 0x38.
- R4: With requested pre-emphasis p below 3 and requested swing at or above 3-p, the swing becomes 3-p and the swing max flag (byte bit 2) is set.
- R5: Otherwise the requested levels pass through unchanged with no flags set. Byte layout: bits [1:0] swing, bit 2 swing-max flag, bits [4:3] pre-emphasis, bit 5 pre-emphasis-max flag, bits [7:6] zero. Lane i's byte is `lane_cfg_o[8*i+7:8*i]`.
- R6: The post-cursor2 request for lane i is `pc2_req_i[2*i+1:2*i]`. A value of 3 becomes nibble 0x7 (level 3 plus max flag at nibble bit 2); values 0 to 2 pass unchanged. Lane i's nibble is `pc2_cfg_o[4*i+3:4*i]`, i.e. byte i>>1, nibble position (i&1)*4.
- R7: Lanes with index at or above `lane_cnt_i` get a zero configuration byte, a zero post-cursor2 nibble and zero PHY levels. No nibble from an earlier result survives, and counts above 4 act as 4.
- R8: The PHY outputs `phy_swing_o`, `phy_preemph_o` and `phy_pc2_o` carry lane i's clamped level at bits [2*i+1:2*i], without any flag.
- R9: While `rst_n` is low all outputs and `done_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample requests and compute a new result |
| adj_req_i | input | 16 | Packed swing/pre-emphasis requests, one nibble per lane |
| pc2_req_i | input | 8 | Packed post-cursor2 requests, two bits per lane |
| lane_cnt_i | input | 3 | Number of active lanes |
| done_o | output | 1 | One-cycle pulse: result valid |
| lane_cfg_o | output | 32 | Per-lane configuration bytes for the sink |
| pc2_cfg_o | output | 16 | Packed post-cursor2 configuration bytes |
| phy_swing_o | output | 8 | Per-lane swing level to the PHY |
| phy_preemph_o | output | 8 | Per-lane pre-emphasis level to the PHY |
| phy_pc2_o | output | 8 | Per-lane post-cursor2 level to the PHY |

## Verification
Some properties are checked on every cycle. Swing plus pre-emphasis never exceeds 3 on any lane. A set pre-emphasis flag always comes with the fixed 0x38 byte. The PHY levels agree with the configuration fields. Lanes beyond the sampled count read zero. `done_o` follows `start_i` by one cycle, and the outputs hold when no start is given.

Other behaviour only the bench's scenarios can show. That covers the exact mapping of request nibbles and post-cursor2 bit pairs to lanes, each clamp branch against known bytes, and the clearing of stale post-cursor2 nibbles when the lane count drops between runs.

// File: rtl/lt_clamp_pkg.sv
package lt_clamp_pkg;

    localparam int LVL_W = 2;
    localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;

    // clamped drive result for one lane
    typedef struct packed {
        logic [LVL_W-1:0] swing;
        logic             swing_max;
        logic [LVL_W-1:0] pre;
        logic             pre_max;
    } drive_t;

    // clamped post-cursor2 result for one lane
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             max;
    } pc2_t;

endpackage

// File: rtl/lt_lane_clamp.sv
module lt_lane_clamp
    import lt_clamp_pkg::*;
(
    input  logic [2*LVL_W-1:0] req_i,
    output drive_t             drv_o
);
    logic [LVL_W-1:0] sw_req;
    logic [LVL_W-1:0] pre_req;
    logic [LVL_W-1:0] sw_ceil;

    assign sw_req  = req_i[LVL_W-1:0];
    assign pre_req = req_i[2*LVL_W-1:LVL_W];
    // the swing ceiling shrinks as pre-emphasis grows
    assign sw_ceil = LVL_TOP - pre_req;

    always_comb begin
        drv_o.swing     = sw_req;
        drv_o.swing_max = 1'b0;
        drv_o.pre       = pre_req;
        drv_o.pre_max   = 1'b0;
        if (pre_req >= LVL_TOP) begin
            drv_o.pre       = LVL_TOP;
            drv_o.pre_max   = 1'b1;
            drv_o.swing     = '0;
        end else if (sw_req >= sw_ceil) begin
            drv_o.swing     = sw_ceil;
            drv_o.swing_max = 1'b1;
        end
    end
endmodule

// File: rtl/lt_pc2_clamp.sv
module lt_pc2_clamp
    import lt_clamp_pkg::*;
(
    input  logic [LVL_W-1:0] req_i,
    output pc2_t             pc2_o
);
    always_comb begin
        if (req_i >= LVL_TOP) begin
            pc2_o.lvl = LVL_TOP;
            pc2_o.max = 1'b1;
        end else begin
            pc2_o.lvl = req_i;
            pc2_o.max = 1'b0;
        end
    end
endmodule

// File: rtl/lt_drive_clamp.sv
module lt_drive_clamp
    import lt_clamp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [8*((LANES+1)/2)-1:0]    adj_req_i,
    input  logic [LVL_W*LANES-1:0]        pc2_req_i,
    input  logic [$clog2(LANES+1)-1:0]    lane_cnt_i,
    output logic                          done_o,
    output logic [8*LANES-1:0]            lane_cfg_o,
    output logic [8*((LANES+1)/2)-1:0]    pc2_cfg_o,
    output logic [LVL_W*LANES-1:0]        phy_swing_o,
    output logic [LVL_W*LANES-1:0]        phy_preemph_o,
    output logic [LVL_W*LANES-1:0]        phy_pc2_o
);
    localparam int NIB_W  = 2 * LVL_W;
    localparam int BYTE_W = 8;
    localparam int PACK_W = BYTE_W * ((LANES + 1) / 2);
    localparam int CFG_W  = BYTE_W * LANES;
    localparam int PHY_W  = LVL_W * LANES;

    typedef struct packed {
        logic             done;
        logic [CFG_W-1:0] cfg;
        logic [PACK_W-1:0] pc2cfg;
        logic [PHY_W-1:0] sw;
        logic [PHY_W-1:0] pre;
        logic [PHY_W-1:0] pc2;
    } st_t;

    st_t    st_d, st_q;
    drive_t drv [LANES];
    pc2_t   pcv [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            lt_lane_clamp u_drv (
                .req_i (adj_req_i[NIB_W*g +: NIB_W]),
                .drv_o (drv[g])
            );
            lt_pc2_clamp u_pc2 (
                .req_i (pc2_req_i[LVL_W*g +: LVL_W]),
                .pc2_o (pcv[g])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.cfg    = '0;
            st_d.pc2cfg = '0;
            st_d.sw     = '0;
            st_d.pre    = '0;
            st_d.pc2    = '0;
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(lane_cnt_i)) begin
                    st_d.cfg[BYTE_W*i +: BYTE_W] = {2'b00, drv[i].pre_max, drv[i].pre,
                                                    drv[i].swing_max, drv[i].swing};
                    st_d.pc2cfg[NIB_W*i +: NIB_W] = {1'b0, pcv[i].max, pcv[i].lvl};
                    st_d.sw [LVL_W*i +: LVL_W] = drv[i].swing;
                    st_d.pre[LVL_W*i +: LVL_W] = drv[i].pre;
                    st_d.pc2[LVL_W*i +: LVL_W] = pcv[i].lvl;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o        = st_q.done;
    assign lane_cfg_o    = st_q.cfg;
    assign pc2_cfg_o     = st_q.pc2cfg;
    assign phy_swing_o   = st_q.sw;
    assign phy_preemph_o = st_q.pre;
    assign phy_pc2_o     = st_q.pc2;

    // ---------------- assertions ----------------
    p_done_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(lane_cfg_o) && $stable(pc2_cfg_o) && $stable(phy_swing_o)));

    generate
        for (g = 0; g < LANES; g++) begin : g_chk
            p_swing_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
                done_o |-> ({1'b0, phy_swing_o[LVL_W*g +: LVL_W]}
                          + {1'b0, phy_preemph_o[LVL_W*g +: LVL_W]}) <= 3'd3);
            p_pre_max_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
                lane_cfg_o[BYTE_W*g + 5] |-> lane_cfg_o[BYTE_W*g +: BYTE_W] == 8'h38);
            p_cfg_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                lane_cfg_o[BYTE_W*g + 7 -: 2] == 2'b00);
            p_phy_matches_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (phy_swing_o[LVL_W*g +: LVL_W]   == lane_cfg_o[BYTE_W*g +: 2]) &&
                (phy_preemph_o[LVL_W*g +: LVL_W] == lane_cfg_o[BYTE_W*g + 3 +: 2]) &&
                (phy_pc2_o[LVL_W*g +: LVL_W]     == pc2_cfg_o[NIB_W*g +: 2]));
            p_pc2_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
                pc2_cfg_o[NIB_W*g + 2] |-> pc2_cfg_o[NIB_W*g +: 2] == 2'd3);
            p_inactive_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (start_i && int'(lane_cnt_i) <= g) |=>
                (lane_cfg_o[BYTE_W*g +: BYTE_W] == '0 && pc2_cfg_o[NIB_W*g +: NIB_W] == '0));
        end
    endgenerate

endmodule

// File: tb/tb_lt_drive_clamp.sv
module tb_lt_drive_clamp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] adj_req_i = '0;
    logic [7:0]  pc2_req_i = '0;
    logic [2:0]  lane_cnt_i = '0;
    logic        done_o;
    logic [31:0] lane_cfg_o;
    logic [15:0] pc2_cfg_o;
    logic [7:0]  phy_swing_o, phy_preemph_o, phy_pc2_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lt_drive_clamp dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .adj_req_i(adj_req_i), .pc2_req_i(pc2_req_i), .lane_cnt_i(lane_cnt_i),
        .done_o(done_o), .lane_cfg_o(lane_cfg_o), .pc2_cfg_o(pc2_cfg_o),
        .phy_swing_o(phy_swing_o), .phy_preemph_o(phy_preemph_o), .phy_pc2_o(phy_pc2_o)
    );

    localparam int NV = 10;
    // R2..R7 stimulus and expected sink bytes
    localparam logic [15:0] V_ADJ [NV] = '{16'h0000, 16'h8521, 16'hC963, 16'h4B7F, 16'hC963,
                                           16'h4B7F, 16'hC963, 16'h8521, 16'hC963, 16'h2EDA};
    localparam logic [7:0]  V_PC2 [NV] = '{8'h00, 8'hE4, 8'hFF, 8'h1B, 8'hFF,
                                           8'h1B, 8'hFF, 8'hE4, 8'hFF, 8'h55};
    localparam logic [2:0]  V_CNT [NV] = '{3'd4, 3'd4, 3'd4, 3'd4, 3'd2,
                                           3'd1, 3'd0, 3'd3, 3'd7, 3'd4};
    localparam logic [31:0] V_CFG [NV] = '{32'h00000000, 32'h10090201, 32'h38150E07,
                                           32'h08150E38, 32'h00000E07, 32'h00000038,
                                           32'h00000000, 32'h00090201, 32'h38150E07,
                                           32'h02383815};
    localparam logic [15:0] V_PCC [NV] = '{16'h0000, 16'h7210, 16'h7777, 16'h0127,
                                           16'h0077, 16'h0007, 16'h0000, 16'h0210,
                                           16'h7777, 16'h1111};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fld(input logic [31:0] w, input int stride, input int off);
        logic [7:0] r = '0;
        for (int i = 0; i < 4; i++) r[2*i +: 2] = w[stride*i + off +: 2];
        return r;
    endfunction

    task automatic run(input logic [15:0] adj, input logic [7:0] pc2, input logic [2:0] cnt,
                       input logic [31:0] ecfg, input logic [15:0] epcc);
        @(negedge clk);
        adj_req_i = adj; pc2_req_i = pc2; lane_cnt_i = cnt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 done pulse", {31'd0, done_o}, 32'd1);
        check("R2/R3/R4/R5/R7 lane cfg", lane_cfg_o, ecfg);
        check("R6/R7 pc2 cfg", {16'd0, pc2_cfg_o}, {16'd0, epcc});
        check("R8 phy swing", {24'd0, phy_swing_o}, {24'd0, fld(ecfg, 8, 0)});
        check("R8 phy preemph", {24'd0, phy_preemph_o}, {24'd0, fld(ecfg, 8, 3)});
        check("R8 phy pc2", {24'd0, phy_pc2_o}, {24'd0, fld({16'd0, epcc}, 4, 0)});
        adj_req_i = ~adj; pc2_req_i = ~pc2; lane_cnt_i = 3'd4;
        @(negedge clk);
        check("R1 done low after pulse", {31'd0, done_o}, 32'd0);
        check("R1 cfg held without start", lane_cfg_o, ecfg);
        check("R1 pc2 held without start", {16'd0, pc2_cfg_o}, {16'd0, epcc});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset done", {31'd0, done_o}, 32'd0);
        check("R9 reset cfg", lane_cfg_o, 32'd0);
        check("R9 reset pc2", {16'd0, pc2_cfg_o}, 32'd0);
        check("R9 reset phy", {8'd0, phy_swing_o, phy_preemph_o, phy_pc2_o}, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) run(V_ADJ[v], V_PC2[v], V_CNT[v], V_CFG[v], V_PCC[v]);

        // R7: full pc2 result, then one lane: stale nibbles must be gone
        run(16'h0000, 8'hFF, 3'd4, 32'h00000000, 16'h7777);
        run(16'h0003, 8'h02, 3'd1, 32'h00000007, 16'h0002);

        // R4: boundary where swing equals the ceiling exactly, lane 3 only
        run(16'h9000, 8'h00, 3'd4, 32'h15000000, 16'h0000);

        // R1: back-to-back starts keep done high and take the newest inputs
        @(negedge clk);
        adj_req_i = 16'h0001; pc2_req_i = 8'h00; lane_cnt_i = 3'd4; start_i = 1'b1;
        @(negedge clk);
        adj_req_i = 16'h0002;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 back-to-back done", {31'd0, done_o}, 32'd1);
        check("R1 back-to-back cfg", lane_cfg_o, 32'h00000002);

        // R9: reset mid-run clears results
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears cfg", lane_cfg_o, 32'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule